// File: doc/BRIEF.md
# Management Bus Command Controller

This block lets a host read and write registers inside external PHY devices over the two-wire management bus, a clock (MDC) and a bidirectional data line (MDIO). The host programs a configuration register with an interface enable and a clock divider. It places outgoing data in a write-data register and then writes a single command word. That word carries the target device address, the register address, an opcode and a go flag. The controller then shifts out a complete clause-22 frame. On a read it releases the data line at turnaround and captures the 16 bits the PHY returns.

While a frame is in flight, the command register reports the controller as not ready. When the last data bit has finished, the controller sets a completion flag in an interrupt status register. The interrupt output is raised when that flag is set and its enable bit is also set. A command is not started if its opcode is invalid, if the interface is disabled, if the divider is zero, or if a frame is already running.

Top module: `mdio_mgmt`

## Requirements
- R1: Registers are selected by `reg_addr_i`: 0 configuration, 1 command, 2 write data (bits 15:0), 3 read data (bits 15:0, read-only), 4 interrupt status, 5 interrupt enable. In the command word the PHY address sits in bits 28:24, the register address in bits 20:16, the opcode in bits 15:14 and the go flag in bit 11. Reading the command register returns the last accepted address and opcode fields in the same positions.
- R2: Opcode 1 (write) sends, first bit first: 32 ones, start 01, opcode 01, the 5-bit PHY address and the 5-bit register address MSB first, turnaround 10, then the 16 write-data bits MSB first. MDIO is driven for all 64 bits.
- R3: Opcode 2 (read) sends the same first 46 bits with opcode 10 and then releases MDIO (`mdio_oe_o` low) for the last 18 bits. It samples `mdio_i` at the 16 rising MDC edges after turnaround, MSB first, and loads the result into the read-data register.
- R4: MDC is low for divider+1 system clocks and then high for divider+1 system clocks, so a frame lasts 128×(divider+1) clocks. Command bit 7 (ready) reads 0 from the clock after the go write until the last bit completes, and reads 1 otherwise.
- R5: Opcodes 0 and 3 are rejected. They produce no MDC edge, ready stays 1 and no completion flag is set.
- R6: A go write starts nothing when configuration bit 6 (enable) is 0, or when the divider in configuration bits 5:0 is zero.
- R7: A command write while a frame runs is ignored. The running frame, its length and the command readback are not changed.
- R8: Interrupt status bit 0 is set when a frame completes and is cleared by writing 1 to it. `irq_o` is high exactly when status bit 0 and enable bit 0 are both set.
- R9: A command write with the go flag at 0 stores the fields and starts no frame.
- R10: While idle, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench sweeps all 32 PHY addresses on writes and all 32 register addresses on reads. For each frame it captures all 64 bits at MDC rising edges. A field placed at the wrong bit position, or sent LSB first, therefore shows up as a frame mismatch. On reads a responder drives data only after turnaround. If the controller keeps driving MDIO there, or samples on the wrong MDC edge, the data it returns is shifted or corrupted. Frame length is measured for several dividers, which catches off-by-one errors in the half-period count. Invalid opcodes, a disabled interface, a zero divider and a clear go flag must all produce zero MDC edges. A command written mid-frame must leave the running frame and its length untouched, which catches a controller that restarts or re-latches fields.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_DW = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CFG   = 3'd0;
  localparam logic [REG_AW-1:0] RA_CMD   = 3'd1;
  localparam logic [REG_AW-1:0] RA_WDATA = 3'd2;
  localparam logic [REG_AW-1:0] RA_RDATA = 3'd3;
  localparam logic [REG_AW-1:0] RA_ISR   = 3'd4;
  localparam logic [REG_AW-1:0] RA_IER   = 3'd5;

  localparam int CMD_PHY_LSB = 24;
  localparam int CMD_REG_LSB = 16;
  localparam int CMD_OP_LSB  = 14;
  localparam int CMD_GO_BIT  = 11;
  localparam int CMD_RDY_BIT = 7;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BAD   = 2'b11
  } mgmt_op_e;

  localparam logic [1:0] FRAME_SOF = 2'b01;
  localparam logic [1:0] FRAME_TA  = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, div_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_q);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  // divider latched per frame so config writes cannot stretch a running frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (start_i) begin
      div_q <= div_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int HDR_W     = 4 + 2 * ADDR_W;
  localparam int TA_POS    = PRE_LEN + HDR_W;
  localparam int DAT_POS   = TA_POS + 2;
  localparam int FRAME_LEN = DAT_POS + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, rd_q;
  logic [DATA_W-1:0]    rx_q;
  logic                 last_bit, in_ta_or_data, in_data;

  assign last_bit      = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign in_ta_or_data = (idx_q >= IDX_W'(TA_POS));
  assign in_data       = (idx_q >= IDX_W'(DAT_POS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= rd_i;
      idx_q  <= '0;
      sh_q   <= {{PRE_LEN{1'b1}}, FRAME_SOF, (rd_i ? OP_READ : OP_WRITE),
                 phy_i, reg_i, FRAME_TA, (rd_i ? {DATA_W{1'b1}} : wdata_i)};
    end else if (busy_q && fall_i) begin
      if (last_bit) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
      end
    end
  end

  // read data is captured on the clock edge that raises MDC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (busy_q && rd_q && rise_i && in_data) begin
      rx_q <= {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last_bit;
  assign rdata_o   = rx_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && in_ta_or_data);
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              start_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [ADDR_W-1:0] reg_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DIV_W-1:0]  cfg_div_o,
  output logic              irq_o
);
  localparam int CFG_EN_BIT = DIV_W;

  logic              cfg_en_q;
  logic [DIV_W-1:0]  cfg_div_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [1:0]        op_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              isr_q, ier_q, rd_q;
  logic              cmd_wr, go, op_ok, cfg_ok;
  logic [1:0]        new_op;

  assign cmd_wr = reg_we_i && (reg_addr_i == RA_CMD) && !busy_i;
  assign new_op = reg_wdata_i[CMD_OP_LSB +: 2];
  assign go     = reg_wdata_i[CMD_GO_BIT];
  assign op_ok  = (new_op == OP_WRITE) || (new_op == OP_READ);
  assign cfg_ok = cfg_en_q && (cfg_div_q != '0);

  assign start_o   = cmd_wr && go && op_ok && cfg_ok;
  assign rd_o      = (new_op == OP_READ);
  assign phy_o     = reg_wdata_i[CMD_PHY_LSB +: ADDR_W];
  assign reg_o     = reg_wdata_i[CMD_REG_LSB +: ADDR_W];
  assign wdata_o   = wdata_q;
  assign cfg_div_o = cfg_div_q;
  assign irq_o     = isr_q && ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en_q  <= 1'b0;
      cfg_div_q <= '0;
      phy_q     <= '0;
      reg_q     <= '0;
      op_q      <= '0;
      wdata_q   <= '0;
      ier_q     <= 1'b0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        RA_CFG: begin
          cfg_en_q  <= reg_wdata_i[CFG_EN_BIT];
          cfg_div_q <= reg_wdata_i[DIV_W-1:0];
        end
        RA_CMD: if (!busy_i) begin
          phy_q <= reg_wdata_i[CMD_PHY_LSB +: ADDR_W];
          reg_q <= reg_wdata_i[CMD_REG_LSB +: ADDR_W];
          op_q  <= new_op;
        end
        RA_WDATA: wdata_q <= reg_wdata_i[DATA_W-1:0];
        RA_IER:   ier_q   <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start_o) rd_q <= rd_o;
      if (done_i && rd_q) rdata_q <= rx_data_i;
    end
  end

  // completion set takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= 1'b0;
    end else if (done_i) begin
      isr_q <= 1'b1;
    end else if (reg_we_i && (reg_addr_i == RA_ISR) && reg_wdata_i[0]) begin
      isr_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CFG: begin
        reg_rdata_o[CFG_EN_BIT]  = cfg_en_q;
        reg_rdata_o[DIV_W-1:0]   = cfg_div_q;
      end
      RA_CMD: begin
        reg_rdata_o[CMD_PHY_LSB +: ADDR_W] = phy_q;
        reg_rdata_o[CMD_REG_LSB +: ADDR_W] = reg_q;
        reg_rdata_o[CMD_OP_LSB +: 2]       = op_q;
        reg_rdata_o[CMD_RDY_BIT]           = !busy_i;
      end
      RA_WDATA: reg_rdata_o[DATA_W-1:0] = wdata_q;
      RA_RDATA: reg_rdata_o[DATA_W-1:0] = rdata_q;
      RA_ISR:   reg_rdata_o[0]          = isr_q;
      RA_IER:   reg_rdata_o[0]          = ier_q;
      default:  reg_rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              start, rd_sel, eng_busy, eng_done, mdc_rise, mdc_fall;
  logic [ADDR_W-1:0] phy_sel, reg_sel;
  logic [DATA_W-1:0] wdata, rx_data;
  logic [DIV_W-1:0]  cfg_div;

  mdio_mgmt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .busy_i     (eng_busy),
    .done_i     (eng_done),
    .rx_data_i  (rx_data),
    .start_o    (start),
    .rd_o       (rd_sel),
    .phy_o      (phy_sel),
    .reg_o      (reg_sel),
    .wdata_o    (wdata),
    .cfg_div_o  (cfg_div),
    .irq_o      (irq_o)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (eng_busy),
    .div_i  (cfg_div),
    .mdc_o  (mdc_o),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .rd_i     (rd_sel),
    .phy_i    (phy_sel),
    .reg_i    (reg_sel),
    .wdata_i  (wdata),
    .rise_i   (mdc_rise),
    .fall_i   (mdc_fall),
    .mdio_i   (mdio_i),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .rdata_o  (rx_data),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             busy,
  input logic             done,
  input logic [DIV_W-1:0] cfg_div,
  input logic             irq_o,
  input logic             mdc_o,
  input logic             mdio_oe_o
);
  logic cmd_wr_idle;
  assign cmd_wr_idle = reg_we_i && (reg_addr_i == 3'd1) && !busy;

  // R4: a frame only ends through its completion strobe
  a_r4_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> busy);

  a_r4_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy);

  a_r5_bad_op_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_idle && (reg_wdata_i[15:14] == 2'b00 || reg_wdata_i[15:14] == 2'b11)) |=> !busy);

  a_r6_div0_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_idle && (cfg_div == '0)) |=> !busy);

  a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(done) || $past(reg_we_i && reg_addr_i == 3'd5)));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));
endmodule

bind mdio_mgmt mdio_mgmt_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .busy       (eng_busy),
  .done       (eng_done),
  .cfg_div    (cfg_div),
  .irq_o      (irq_o),
  .mdc_o      (mdc_o),
  .mdio_oe_o  (mdio_oe_o)
);

// File: tb/mdio_mgmt_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_tb;
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_WD = 3'd2, A_RD = 3'd3,
                         A_ISR = 3'd4, A_IER = 3'd5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2 clk_i = ~clk_i;

  mdio_mgmt u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // PHY responder: capture on MDC rise, drive read data after MDC fall
  int          mdc_edges = 0;
  int          base = 0;
  logic [15:0] rd_val = '0;
  logic        cap_bit [64];
  logic        cap_oe  [64];

  always @(posedge mdc_o) begin
    int i;
    i = mdc_edges - base;
    if (i >= 0 && i < 64) begin
      cap_bit[i] = mdio_o;
      cap_oe[i]  = mdio_oe_o;
    end
    mdc_edges = mdc_edges + 1;
  end

  always @(negedge mdc_o) begin
    int p;
    p = mdc_edges - base - 1;
    if (p >= 47 && p < 63) mdio_i = rd_val[62-p];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  function automatic logic [31:0] mk_cmd(input int phy, input int rg, input int op, input bit go);
    return (32'(phy & 31) << 24) | (32'(rg & 31) << 16) | (32'(op & 3) << 14) | (32'(go) << 11);
  endfunction

  // issue a command, count clocks with ready low; optionally poke a second command mid-frame
  task automatic run_cmd(input logic [31:0] cmd, input bit poke, input logic [31:0] poke_cmd,
                         output int busy_cyc, output int edges);
    int i;
    base = mdc_edges;
    @(negedge clk_i);
    reg_addr_i = A_CMD; reg_wdata_i = cmd; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    busy_cyc = 0;
    while (!reg_rdata_o[7] && busy_cyc < 5000) begin
      busy_cyc++;
      if (poke && busy_cyc == 20) begin
        reg_wdata_i = poke_cmd; reg_we_i = 1'b1;
      end else begin
        reg_we_i = 1'b0;
      end
      @(negedge clk_i);
    end
    reg_we_i = 1'b0;
    for (i = 0; i < 4; i++) @(negedge clk_i);
    edges = mdc_edges - base;
  endtask

  task automatic chk_frame(input logic [63:0] exp, input int nbits, input bit rd_mode, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < nbits; i++) begin
      if (cap_bit[i] !== exp[63-i]) bad++;
      if (cap_oe[i] !== 1'b1) bad++;
    end
    if (rd_mode) for (int i = nbits; i < 64; i++) if (cap_oe[i] !== 1'b0) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] exp;
    int bc, ed;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 / R4 reset state
    rd(A_CMD, d);
    chk(d[7] == 1'b1, "R4 ready after reset", d[7], 1);
    chk(mdc_o == 0 && mdio_oe_o == 0, "R10 idle pins", {mdc_o, mdio_oe_o}, 0);
    chk(irq_o == 0, "R8 irq after reset", irq_o, 0);
    rd(A_ISR, d);
    chk(d[0] == 0, "R8 isr after reset", d[0], 0);

    // R2 write sweep over every PHY address, divider 1
    wr(A_CFG, 32'h41);
    for (int a = 0; a < 32; a++) begin
      logic [15:0] wd;
      wd = 16'((a * 16'h0A53) ^ 16'hC3A5);
      wr(A_WD, {16'h0, wd});
      run_cmd(mk_cmd(a, 31 - a, 1, 1), 0, 0, bc, ed);
      exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(a), 5'(31 - a), 2'b10, wd};
      chk_frame(exp, 64, 0, "R2 write frame");
      chk(bc == 256, "R4 frame length div1", bc, 256);
      chk(ed == 64, "R2 mdc edge count", ed, 64);
      rd(A_CMD, d);
      chk(d[28:24] == 5'(a) && d[20:16] == 5'(31 - a) && d[15:14] == 2'b01,
          "R1 command readback", d, mk_cmd(a, 31 - a, 1, 0));
      chk(mdc_o == 0 && mdio_oe_o == 0, "R10 idle after frame", {mdc_o, mdio_oe_o}, 0);
      rd(A_ISR, d);
      chk(d[0] == 1, "R8 completion flag", d[0], 1);
      wr(A_ISR, 32'h1);
    end

    // R3 read sweep over every register address
    for (int r = 0; r < 32; r++) begin
      rd_val = 16'((r * 16'h1357) ^ 16'h8E21);
      run_cmd(mk_cmd(7, r, 2, 1), 0, 0, bc, ed);
      exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd7, 5'(r), 18'h0};
      chk_frame(exp, 46, 1, "R3 read frame and release");
      rd(A_RD, d);
      chk(d == {16'h0, rd_val}, "R3 read data", d, rd_val);
      wr(A_ISR, 32'h1);
    end

    // R4 divider sweep
    for (int dv = 1; dv <= 4; dv++) begin
      wr(A_CFG, 32'h40 | 32'(dv));
      run_cmd(mk_cmd(3, 5, 1, 1), 0, 0, bc, ed);
      chk(bc == 128 * (dv + 1), "R4 frame length vs divider", bc, 128 * (dv + 1));
      chk(ed == 64, "R4 edge count vs divider", ed, 64);
      wr(A_ISR, 32'h1);
    end

    // R5 rejected opcodes
    wr(A_CFG, 32'h41);
    for (int op = 0; op < 4; op += 3) begin
      run_cmd(mk_cmd(1, 2, op, 1), 0, 0, bc, ed);
      chk(bc == 0 && ed == 0, "R5 bad opcode no transfer", ed, 0);
      rd(A_ISR, d);
      chk(d[0] == 0, "R5 bad opcode no completion", d[0], 0);
    end

    // R6 disabled interface and zero divider
    wr(A_CFG, 32'h03);
    run_cmd(mk_cmd(1, 2, 1, 1), 0, 0, bc, ed);
    chk(bc == 0 && ed == 0, "R6 disabled no transfer", ed, 0);
    wr(A_CFG, 32'h40);
    run_cmd(mk_cmd(1, 2, 2, 1), 0, 0, bc, ed);
    chk(bc == 0 && ed == 0, "R6 zero divider no transfer", ed, 0);

    // R9 go flag clear
    wr(A_CFG, 32'h41);
    run_cmd(mk_cmd(9, 4, 1, 0), 0, 0, bc, ed);
    chk(bc == 0 && ed == 0, "R9 no go no transfer", ed, 0);
    rd(A_CMD, d);
    chk(d[28:24] == 5'd9 && d[20:16] == 5'd4, "R9 fields stored", d, mk_cmd(9, 4, 1, 0));

    // R7 command written mid-frame is ignored
    wr(A_WD, 32'h0000_5AA5);
    run_cmd(mk_cmd(12, 6, 1, 1), 1, mk_cmd(21, 17, 2, 1), bc, ed);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd12, 5'd6, 2'b10, 16'h5AA5};
    chk_frame(exp, 64, 0, "R7 frame unchanged by busy write");
    chk(bc == 256, "R7 length unchanged", bc, 256);
    rd(A_CMD, d);
    chk(d[28:24] == 5'd12 && d[20:16] == 5'd6 && d[15:14] == 2'b01, "R7 readback unchanged",
        d, mk_cmd(12, 6, 1, 0));

    // R8 interrupt gating and clear
    chk(irq_o == 0, "R8 irq masked", irq_o, 0);
    wr(A_IER, 32'h1);
    #0.5;
    chk(irq_o == 1, "R8 irq enabled", irq_o, 1);
    wr(A_ISR, 32'h1);
    #0.5;
    chk(irq_o == 0, "R8 irq cleared", irq_o, 0);
    rd(A_ISR, d);
    chk(d[0] == 0, "R8 isr cleared", d[0], 0);
    run_cmd(mk_cmd(2, 2, 2, 1), 0, 0, bc, ed);
    chk(irq_o == 1, "R8 irq on completion", irq_o, 1);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule